// File: doc/BRIEF.md
# DPLL Operating-State Controller

This block supervises a digital PLL's choice of input reference and decides what state the loop is in. It has five states: initial prelock, relock (prelock-2), locked, loss-of-lock and holdover. It makes its decisions from a once-per-second tick, a phase-lock flag from the lock detector, a valid bit per reference, and an activity alarm and a hard-frequency alarm per reference. Every timer counts seconds, so all timing follows the tick and not the system clock.

A reference that fails is marked invalid, and an invalidate strobe reports it. What happens next depends on the state. The controller may switch at once to the best remaining reference. It may instead wait out a two-second grace window. If nothing usable remains, it falls into holdover. A programmable phase-lock timeout bounds each attempt to regain lock. In revertive mode the controller also moves back to a higher-priority reference as soon as one becomes usable. References are priority-ordered by index, and index 0 is the highest priority.

Top module: `dpll_state_ctrl`

## Requirements
- R1: Synchronous reset puts the block in the initial prelock state with selRef = 0. The invalidate strobes, the phase-lock alarm and the lock pin are all low. State codes: 0 = prelock, 1 = prelock-2, 2 = locked, 3 = loss-of-lock, 4 = holdover.
- R2: Prelock or prelock-2 advances to locked only on the second consecutive tick with phaseLocked high. Any cycle with phaseLocked low restarts this count.
- R3: lockPin is high exactly while the state is locked and lockPinEn is 1. It is low at all other times.
- R4: In locked, phaseLocked going low moves the block to loss-of-lock on the next clock edge.
- R5: In loss-of-lock, two consecutive ticks with phaseLocked high return the block to locked.
- R6: In prelock, prelock-2 or locked, an activity or hard alarm on the selected reference pulses that reference's bit of invalidateStb in the same cycle. If another usable reference exists, the next state is prelock-2 on that reference.
- R7: In prelock-2 and loss-of-lock, the tick that completes lockTimeout seconds without lock pulses phaseLockAlarm together with the selected reference's invalidate bit.
- R8: When that timeout fires and another usable reference exists, the block re-enters prelock-2 with selRef set to the lowest-index usable reference.
- R9: In prelock-2 with revertEn = 1, a usable reference with a lower index than selRef causes re-entry to prelock-2 on that reference on the next edge.
- R10: With the selected reference invalid and no alternate usable, the block enters holdover on the second tick of invalidity.
- R11: An invalidated reference stays unusable while its refValid bit stays 1. It becomes usable again only after refValid drops to 0 and then returns to 1.
- R12: In holdover, any usable reference moves the block to prelock-2 on the lowest-index usable reference on the next edge.
- R13: In loss-of-lock, an alarm on the selected reference does not switch at once. On the second tick of invalidity the block goes to prelock-2 on an alternate, or to holdover if there is none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| secTick | input | 1 | One-cycle pulse once per second |
| phaseLocked | input | 1 | Lock detector reports phase lock |
| refValid | input | NUM_REFS | Per-reference valid bits, index 0 highest priority |
| refActAlarm | input | NUM_REFS | Per-reference activity alarm |
| refHardAlarm | input | NUM_REFS | Per-reference hard frequency-limit alarm |
| lockTimeout | input | TMR_W | Phase-lock timeout in seconds (nominally 100) |
| revertEn | input | 1 | Enables revertive switching to higher priority |
| lockPinEn | input | 1 | Enables the lock pin output |
| state | output | 3 | Current operating state code |
| selRef | output | IDX_W | Index of the selected reference |
| invalidateStb | output | NUM_REFS | One-cycle strobe naming the invalidated reference |
| phaseLockAlarm | output | 1 | One-cycle pulse on phase-lock timeout |
| lockPin | output | 1 | High while locked, if enabled |

## Verification
The assertions check some properties on every cycle. The locked state is entered only from a cycle that carried both a tick and phase lock. Loss of lock in locked is followed at once by the loss-of-lock state. The invalidate strobe never names more than one reference. A phase-lock alarm always comes with an invalidate. Holdover is entered only when no alternate was usable. Other behaviour needs a sequence of seconds, so only the directed scenarios can show it. This covers the exact tick on which a timeout or grace window expires, which alternate gets picked, how an exclusion persists and then clears, and revertive preemption.

// File: rtl/dpll_ctrl_pkg.sv
package dpll_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_PRELOCK  = 3'd0,
    ST_PRELOCK2 = 3'd1,
    ST_LOCKED   = 3'd2,
    ST_LOSSLOCK = 3'd3,
    ST_HOLDOVER = 3'd4
  } dpllState_e;

  // Strobes from the state machine to the reference datapath
  typedef struct packed {
    logic clrTimers;   // state entry: restart qualify, timeout and grace timers
    logic loadAlt;     // select lowest usable reference other than current
    logic loadBest;    // select lowest usable reference overall
    logic invalidate;  // exclude current reference and strobe it
  } ctrlStrb_t;

endpackage

// File: rtl/dpll_ref_datapath.sv
module dpll_ref_datapath
  import dpll_ctrl_pkg::*;
#(
  parameter int NUM_REFS   = 4,
  parameter int TMR_W      = 8,
  parameter int QUAL_SECS  = 2,
  parameter int GRACE_SECS = 2,
  localparam int IDX_W     = (NUM_REFS > 1) ? $clog2(NUM_REFS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                secTick,
  input  logic                phaseLocked,
  input  logic [NUM_REFS-1:0] refValid,
  input  logic [NUM_REFS-1:0] refActAlarm,
  input  logic [NUM_REFS-1:0] refHardAlarm,
  input  logic [TMR_W-1:0]    lockTimeout,
  input  ctrlStrb_t           strb,
  output logic [IDX_W-1:0]    selRef,
  output logic [NUM_REFS-1:0] invalidateStb,
  output logic                selInvalid,
  output logic                selUsable,
  output logic                selAlarm,
  output logic                altAvail,
  output logic                betterAvail,
  output logic                anyAvail,
  output logic                qualDone,
  output logic                tmoDone,
  output logic                graceDone
);

  localparam int QC_W = $clog2(QUAL_SECS + 1);
  localparam int GC_W = $clog2(GRACE_SECS + 1);

  logic [NUM_REFS-1:0] exclQ, effValid, selMask, altMask;
  logic [IDX_W-1:0]    selQ, altIdx, bestIdx;
  logic [QC_W-1:0]     qualCnt;
  logic [GC_W-1:0]     graceCnt;
  logic [TMR_W-1:0]    tmoCnt;

  function automatic logic [IDX_W-1:0] lowIdx(input logic [NUM_REFS-1:0] v);
    lowIdx = '0;
    for (int i = NUM_REFS - 1; i >= 0; i--) begin
      if (v[i]) lowIdx = IDX_W'(i);
    end
  endfunction

  assign selMask     = NUM_REFS'(1) << selQ;
  assign effValid    = refValid & ~exclQ;
  assign altMask     = effValid & ~selMask;
  assign altIdx      = lowIdx(altMask);
  assign bestIdx     = lowIdx(effValid);
  assign altAvail    = |altMask;
  assign anyAvail    = |effValid;
  assign betterAvail = |(effValid & (selMask - NUM_REFS'(1)));
  assign selAlarm    = |((refActAlarm | refHardAlarm) & selMask);
  assign selUsable   = |(effValid & selMask);
  assign selInvalid  = !selUsable || selAlarm;
  assign selRef      = selQ;
  assign invalidateStb = strb.invalidate ? selMask : '0;

  assign qualDone  = secTick && phaseLocked && (qualCnt >= QC_W'(QUAL_SECS - 1));
  assign graceDone = secTick && selInvalid && (graceCnt >= GC_W'(GRACE_SECS - 1));
  assign tmoDone   = secTick && (({1'b0, tmoCnt} + (TMR_W+1)'(1)) >= {1'b0, lockTimeout});

  // Reference selection and exclusion mask
  always_ff @(posedge clk) begin
    if (rst) begin
      selQ  <= '0;
      exclQ <= '0;
    end else begin
      exclQ <= (exclQ & refValid) | (strb.invalidate ? selMask : '0);
      if (strb.loadAlt)       selQ <= altIdx;
      else if (strb.loadBest) selQ <= bestIdx;
    end
  end

  // Seconds timers
  always_ff @(posedge clk) begin
    if (rst || strb.clrTimers) begin
      qualCnt  <= '0;
      graceCnt <= '0;
      tmoCnt   <= '0;
    end else begin
      if (!phaseLocked)                    qualCnt <= '0;
      else if (secTick && qualCnt != '1)   qualCnt <= qualCnt + 1'b1;
      if (!selInvalid)                     graceCnt <= '0;
      else if (secTick && graceCnt != '1)  graceCnt <= graceCnt + 1'b1;
      if (secTick && tmoCnt != '1)         tmoCnt <= tmoCnt + 1'b1;
    end
  end

  AST_STB_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(invalidateStb));  // R6

  AST_EXCL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    ($past(invalidateStb) != '0 && ($past(invalidateStb) & refValid & $past(refValid)) != '0)
      |-> (effValid & $past(invalidateStb)) == '0);  // R11

endmodule

// File: rtl/dpll_state_fsm.sv
module dpll_state_fsm
  import dpll_ctrl_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       phaseLocked,
  input  logic       revertEn,
  input  logic       lockPinEn,
  input  logic       selInvalid,
  input  logic       selUsable,
  input  logic       selAlarm,
  input  logic       altAvail,
  input  logic       betterAvail,
  input  logic       anyAvail,
  input  logic       qualDone,
  input  logic       tmoDone,
  input  logic       graceDone,
  output dpllState_e stateQ,
  output ctrlStrb_t  strb,
  output logic       phaseLockAlarm,
  output logic       lockPin
);

  dpllState_e stateNxt;

  always_comb begin
    stateNxt       = stateQ;
    strb           = '0;
    phaseLockAlarm = 1'b0;
    unique case (stateQ)
      ST_PRELOCK, ST_PRELOCK2, ST_LOCKED: begin
        if (selInvalid) begin
          strb.invalidate = selAlarm && selUsable;
          if (altAvail) begin
            stateNxt     = ST_PRELOCK2;
            strb.loadAlt = 1'b1;
          end else if (graceDone) begin
            stateNxt = ST_HOLDOVER;
          end
        end else if (stateQ == ST_PRELOCK2 && revertEn && betterAvail) begin
          stateNxt      = ST_PRELOCK2;
          strb.loadBest = 1'b1;
        end else if (stateQ == ST_LOCKED) begin
          if (!phaseLocked) stateNxt = ST_LOSSLOCK;
        end else if (qualDone) begin
          stateNxt = ST_LOCKED;
        end else if (stateQ == ST_PRELOCK2 && tmoDone) begin
          phaseLockAlarm  = 1'b1;
          strb.invalidate = 1'b1;
          if (altAvail) begin
            stateNxt     = ST_PRELOCK2;
            strb.loadAlt = 1'b1;
          end
        end
      end
      ST_LOSSLOCK: begin
        if (selInvalid) begin
          strb.invalidate = selAlarm && selUsable;
          if (graceDone) begin
            if (altAvail) begin
              stateNxt     = ST_PRELOCK2;
              strb.loadAlt = 1'b1;
            end else begin
              stateNxt = ST_HOLDOVER;
            end
          end
        end else if (qualDone) begin
          stateNxt = ST_LOCKED;
        end else if (tmoDone) begin
          phaseLockAlarm  = 1'b1;
          strb.invalidate = 1'b1;
          if (altAvail) begin
            stateNxt     = ST_PRELOCK2;
            strb.loadAlt = 1'b1;
          end
        end
      end
      ST_HOLDOVER: begin
        if (anyAvail) begin
          stateNxt      = ST_PRELOCK2;
          strb.loadBest = 1'b1;
        end
      end
      default: stateNxt = ST_PRELOCK;
    endcase
    strb.clrTimers = (stateNxt != stateQ) || strb.loadAlt || strb.loadBest;
  end

  always_ff @(posedge clk) begin
    if (rst) stateQ <= ST_PRELOCK;
    else     stateQ <= stateNxt;
  end

  assign lockPin = lockPinEn && (stateQ == ST_LOCKED);

  AST_LOCK_NEEDS_QUAL: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_LOCKED && $past(stateQ) != ST_LOCKED) |-> ($past(phaseLocked) && $past(qualDone)));  // R2

  AST_LOL_IMMEDIATE: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_LOCKED && !phaseLocked && !selInvalid) |=> stateQ == ST_LOSSLOCK);  // R4

  AST_ALARM_INVALIDATES: assert property (@(posedge clk) disable iff (rst)
    phaseLockAlarm |-> (strb.invalidate && tmoDone));  // R7

  AST_HOLD_NO_ALT: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_HOLDOVER && $past(stateQ) != ST_HOLDOVER) |-> !$past(altAvail));  // R10

  AST_ALARM_SWITCH: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_LOCKED && selAlarm && selUsable && altAvail) |=> stateQ == ST_PRELOCK2);  // R6

endmodule

// File: rtl/dpll_state_ctrl.sv
module dpll_state_ctrl
  import dpll_ctrl_pkg::*;
#(
  parameter int NUM_REFS   = 4,
  parameter int TMR_W      = 8,
  parameter int QUAL_SECS  = 2,
  parameter int GRACE_SECS = 2,
  localparam int IDX_W     = (NUM_REFS > 1) ? $clog2(NUM_REFS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                secTick,
  input  logic                phaseLocked,
  input  logic [NUM_REFS-1:0] refValid,
  input  logic [NUM_REFS-1:0] refActAlarm,
  input  logic [NUM_REFS-1:0] refHardAlarm,
  input  logic [TMR_W-1:0]    lockTimeout,
  input  logic                revertEn,
  input  logic                lockPinEn,
  output logic [2:0]          state,
  output logic [IDX_W-1:0]    selRef,
  output logic [NUM_REFS-1:0] invalidateStb,
  output logic                phaseLockAlarm,
  output logic                lockPin
);

  ctrlStrb_t  strb;
  dpllState_e stateQ;
  logic selInvalid, selUsable, selAlarm, altAvail, betterAvail, anyAvail;
  logic qualDone, tmoDone, graceDone;

  dpll_ref_datapath #(
    .NUM_REFS(NUM_REFS), .TMR_W(TMR_W),
    .QUAL_SECS(QUAL_SECS), .GRACE_SECS(GRACE_SECS)
  ) u_dp (
    .clk(clk), .rst(rst), .secTick(secTick), .phaseLocked(phaseLocked),
    .refValid(refValid), .refActAlarm(refActAlarm), .refHardAlarm(refHardAlarm),
    .lockTimeout(lockTimeout), .strb(strb), .selRef(selRef),
    .invalidateStb(invalidateStb), .selInvalid(selInvalid), .selUsable(selUsable),
    .selAlarm(selAlarm), .altAvail(altAvail), .betterAvail(betterAvail),
    .anyAvail(anyAvail), .qualDone(qualDone), .tmoDone(tmoDone), .graceDone(graceDone)
  );

  dpll_state_fsm u_fsm (
    .clk(clk), .rst(rst), .phaseLocked(phaseLocked), .revertEn(revertEn),
    .lockPinEn(lockPinEn), .selInvalid(selInvalid), .selUsable(selUsable),
    .selAlarm(selAlarm), .altAvail(altAvail), .betterAvail(betterAvail),
    .anyAvail(anyAvail), .qualDone(qualDone), .tmoDone(tmoDone),
    .graceDone(graceDone), .stateQ(stateQ), .strb(strb),
    .phaseLockAlarm(phaseLockAlarm), .lockPin(lockPin)
  );

  assign state = stateQ;

  AST_LOCKPIN_LOCKED_ONLY: assert property (@(posedge clk) disable iff (rst)
    lockPin |-> (state == 3'd2));  // R3

endmodule

// File: tb/tb_dpll_state_ctrl.sv
module tb_dpll_state_ctrl;

  localparam int N = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic secTick = 1'b0, phaseLocked = 1'b0, revertEn = 1'b0, lockPinEn = 1'b1;
  logic [N-1:0] refValid = '0, refActAlarm = '0, refHardAlarm = '0;
  logic [7:0]   lockTimeout = 8'd100;
  logic [2:0]   state;
  logic [1:0]   selRef;
  logic [N-1:0] invalidateStb;
  logic         phaseLockAlarm, lockPin;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [N-1:0] stbSeen;
  logic         almSeen;

  always #5 clk = ~clk;

  dpll_state_ctrl dut (
    .clk(clk), .rst(rst), .secTick(secTick), .phaseLocked(phaseLocked),
    .refValid(refValid), .refActAlarm(refActAlarm), .refHardAlarm(refHardAlarm),
    .lockTimeout(lockTimeout), .revertEn(revertEn), .lockPinEn(lockPinEn),
    .state(state), .selRef(selRef), .invalidateStb(invalidateStb),
    .phaseLockAlarm(phaseLockAlarm), .lockPin(lockPin)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One-second tick: pulse for one cycle, capture strobes mid-cycle
  task automatic tickSec();
    @(negedge clk);
    secTick = 1'b1;
    #2;
    stbSeen = invalidateStb;
    almSeen = phaseLockAlarm;
    @(negedge clk);
    secTick = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic testReset();
    check("R1 state", state, 0);
    check("R1 selRef", selRef, 0);
    check("R1 lockPin", lockPin, 0);
    check("R1 stb", invalidateStb, 0);
    check("R1 alarm", phaseLockAlarm, 0);
  endtask

  task automatic testQualify();
    refValid = 4'b1111; phaseLocked = 1'b1;
    tickSec();
    check("R2 one tick", state, 0);
    @(negedge clk); phaseLocked = 1'b0;
    @(negedge clk); phaseLocked = 1'b1;
    tickSec();
    check("R2 restart after drop", state, 0);
    tickSec();
    check("R2 locked", state, 2);
    check("R3 lockPin on", lockPin, 1);
    lockPinEn = 1'b0; #1;
    check("R3 lockPin disabled", lockPin, 0);
    lockPinEn = 1'b1;
  endtask

  task automatic testLossOfLock();
    @(negedge clk); phaseLocked = 1'b0;
    @(negedge clk);
    check("R4 loss-of-lock", state, 3);
    check("R3 lockPin off", lockPin, 0);
    phaseLocked = 1'b1;
    tickSec();
    check("R5 one tick", state, 3);
    tickSec();
    check("R5 relocked", state, 2);
  endtask

  task automatic testAlarmSwitch();
    @(negedge clk); refActAlarm = 4'b0001;
    #2;
    check("R6 strobe", invalidateStb, 1);
    @(negedge clk);
    check("R6 prelock2", state, 1);
    check("R6 alt sel", selRef, 1);
    refActAlarm = '0; revertEn = 1'b1;
    idle(2);
    check("R11 excluded no revert", selRef, 1);
    refValid = 4'b1110;
    @(negedge clk); refValid = 4'b1111;
    @(negedge clk);
    check("R9 revert sel", selRef, 0);
    check("R9 revert state", state, 1);
  endtask

  task automatic testTimeout();
    revertEn = 1'b0; phaseLocked = 1'b0; lockTimeout = 8'd3;
    tickSec();
    check("R7 no early alarm", almSeen, 0);
    tickSec();
    check("R7 still sel0", selRef, 0);
    tickSec();
    check("R7 alarm", almSeen, 1);
    check("R7 strobe", stbSeen, 1);
    check("R8 reentry state", state, 1);
    check("R8 alt sel", selRef, 1);
  endtask

  task automatic testHoldover();
    @(negedge clk); refValid = 4'b0010;
    tickSec(); tickSec(); tickSec();
    check("R7 alarm no alt", almSeen, 1);
    check("R7 strobe ref1", stbSeen, 2);
    check("R10 stays prelock2", state, 1);
    tickSec();
    check("R10 grace one tick", state, 1);
    tickSec();
    check("R10 holdover", state, 4);
    @(negedge clk); refValid = 4'b0110;
    @(negedge clk);
    check("R12 exit state", state, 1);
    check("R12 exit sel", selRef, 2);
  endtask

  task automatic testLolAlarm();
    refValid = 4'b1100; lockTimeout = 8'd100; phaseLocked = 1'b1;
    tickSec(); tickSec();
    check("R2 locked on ref2", state, 2);
    @(negedge clk); phaseLocked = 1'b0;
    @(negedge clk); refHardAlarm = 4'b0100;
    #2;
    check("R13 strobe", invalidateStb, 4);
    @(negedge clk);
    check("R13 no immediate switch", state, 3);
    tickSec();
    check("R13 grace one tick", state, 3);
    tickSec();
    check("R13 to prelock2", state, 1);
    check("R13 alt sel", selRef, 3);
  endtask

  task automatic testLockedNoAlt();
    refHardAlarm = '0; refValid = 4'b1000; phaseLocked = 1'b1;
    tickSec(); tickSec();
    check("R2 locked on ref3", state, 2);
    @(negedge clk); refActAlarm = 4'b1000;
    #2;
    check("R6 strobe ref3", invalidateStb, 8);
    @(negedge clk);
    check("R10 locked during grace", state, 2);
    tickSec();
    check("R10 grace one tick", state, 2);
    tickSec();
    check("R10 holdover from locked", state, 4);
    check("R3 lockPin in holdover", lockPin, 0);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #200000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    testReset();
    testQualify();
    testLossOfLock();
    testAlarmSwitch();
    testTimeout();
    testHoldover();
    testLolAlarm();
    testLockedNoAlt();
    finishRun();
  end

endmodule